// File: doc/BRIEF.md
# Configurable Serial Transmit Shifter

This block turns parallel words from a transmit coding stage into a serial bit stream, one bit per clock. At each word boundary it takes a word of 8, 10, 16, 20, 32 or 40 bits, selected at run time by a 3-bit code. It can complement every bit of the word and can send the word most significant bit first instead of least significant bit first. The invert, reverse and width settings are captured only at the boundary. A word that is already being shifted therefore never mixes two settings, and a control that changes mid-word cannot corrupt it.

The upstream source watches `word_start`. That pulse marks the first serial bit of each word and shows that the presented word has just been taken. The source then sets up the next word before the current one runs out. If no valid word is present at a boundary, the block sends an idle word of alternating ones and zeros and raises `underrun` for its whole length.

Top module: `ser_tx_core`

## Requirements
- R1: The width code maps as follows: 0 gives 8 bits, 1 gives 10, 2 gives 16, 3 gives 20, 4 gives 32, 5 gives 40, and the unused codes 6 and 7 give 10. Consecutive `word_start` pulses lie exactly the selected width apart in cycles.
- R2: With `reverse` low, the serial bits of a width-W word are `word_in[0]`, `word_in[1]`, through `word_in[W-1]`, in that order. Bits at and above position W are not sent.
- R3: With `reverse` high, the serial bits are `word_in[W-1]` first, down to `word_in[0]` last.
- R4: With `invert` high, every data bit sent for that word is the complement of the bit R2 or R3 would send.
- R5: `word_in`, `word_valid`, `width_sel`, `invert` and `reverse` are sampled only on the load edge. Changing them on any other edge has no effect on the serial output.
- R6: A word loads on the clock edge that follows the cycle carrying the previous word's last bit. `word_start` is high only during the cycle carrying a word's first bit.
- R7: If `word_valid` is low on a load edge, the block sends W bits of idle pattern 1,0,1,0,... (first bit 1), where W is the width sampled on that edge. Invert and reverse do not apply to the idle pattern. `underrun` is high for exactly the cycles of that idle word.
- R8: Reset is synchronous and active high. While it is applied, `ser_out`, `word_start` and `underrun` are low. The first edge after release is a load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 40 | Parallel word; only the low W bits are used |
| word_valid | input | 1 | Word is present at the boundary |
| width_sel | input | 3 | Word width code |
| invert | input | 1 | Complement the word's bits |
| reverse | input | 1 | Send the MSB of the word first |
| ser_out | output | 1 | Serial data bit |
| word_start | output | 1 | High on the first bit of each word |
| underrun | output | 1 | High while an idle word is sent |

## Verification
The assertions assume that reset is applied at time zero and held for at least one edge. They also assume that inputs change only away from the rising edge, since several properties compare the output with the inputs as sampled one edge earlier. The stimulus holds reset from the start and drives every input on the falling edge. Between boundaries it deliberately toggles the controls, the data and the width code. This shows that only the values present on the load edge count.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int MAX_W  = 40;
    localparam int CNT_W  = $clog2(MAX_W + 1);
    localparam int CODE_W = 3;

    // Idle pattern: LSB is 1, so the line shows 1,0,1,0,...
    localparam logic [MAX_W-1:0] IDLE_BITS = {(MAX_W/2){2'b01}};

    typedef struct packed {
        logic [MAX_W-1:0] bits;   // already masked, inverted, ordered
        logic [CNT_W-1:0] len;    // number of bits to send
        logic             idle;   // word is idle fill
    } ser_word_t;

    function automatic logic [CNT_W-1:0] width_of(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    return CNT_W'(8);
            3'd1:    return CNT_W'(10);
            3'd2:    return CNT_W'(16);
            3'd3:    return CNT_W'(20);
            3'd4:    return CNT_W'(32);
            3'd5:    return CNT_W'(40);
            default: return CNT_W'(10);
        endcase
    endfunction

endpackage

// File: rtl/ser_word_prep.sv
module ser_word_prep
    import ser_pkg::*;
(
    input  logic [MAX_W-1:0]  word_in,
    input  logic              word_valid,
    input  logic [CODE_W-1:0] width_sel,
    input  logic              invert,
    input  logic              reverse,
    output ser_word_t         prep
);
    logic [CNT_W-1:0] len;
    logic [MAX_W-1:0] mask;
    logic [MAX_W-1:0] flipped;
    logic [MAX_W-1:0] ordered;
    logic [MAX_W-1:0] polar;

    assign len  = width_of(width_sel);
    assign mask = {MAX_W{1'b1}} >> (MAX_W - int'(len));

    // Full-width mirror; shifting down by (MAX_W - len) aligns it to width len.
    for (genvar i = 0; i < MAX_W; i++) begin : g_mirror
        assign flipped[i] = word_in[MAX_W-1-i];
    end

    always_comb begin
        ordered = reverse ? (flipped >> (MAX_W - int'(len))) : word_in;
        polar   = invert ? ~ordered : ordered;
        prep.len  = len;
        prep.idle = ~word_valid;
        prep.bits = (word_valid ? polar : IDLE_BITS) & mask;
    end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
    import ser_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ser_word_t next_word,
    output logic      ser_out,
    output logic      word_start,
    output logic      underrun
);
    logic [MAX_W-1:0] sh;
    logic [CNT_W-1:0] rem;     // bits still to send after the current one
    logic             boundary;

    assign boundary = (rem == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh         <= '0;
            rem        <= '0;
            ser_out    <= 1'b0;
            word_start <= 1'b0;
            underrun   <= 1'b0;
        end else if (boundary) begin
            ser_out    <= next_word.bits[0];
            sh         <= next_word.bits >> 1;
            rem        <= next_word.len - CNT_W'(1);
            word_start <= 1'b1;
            underrun   <= next_word.idle;
        end else begin
            ser_out    <= sh[0];
            sh         <= sh >> 1;
            rem        <= rem - CNT_W'(1);
            word_start <= 1'b0;
        end
    end
endmodule

// File: rtl/ser_tx_core.sv
module ser_tx_core
    import ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MAX_W-1:0]  word_in,
    input  logic              word_valid,
    input  logic [CODE_W-1:0] width_sel,
    input  logic              invert,
    input  logic              reverse,
    output logic              ser_out,
    output logic              word_start,
    output logic              underrun
);
    ser_word_t prep;

    ser_word_prep u_prep (
        .word_in    (word_in),
        .word_valid (word_valid),
        .width_sel  (width_sel),
        .invert     (invert),
        .reverse    (reverse),
        .prep       (prep)
    );

    ser_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .next_word  (prep),
        .ser_out    (ser_out),
        .word_start (word_start),
        .underrun   (underrun)
    );
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk
    import ser_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              word_lsb,
    input logic              word_valid,
    input logic [CODE_W-1:0] width_sel,
    input logic              invert,
    input logic              reverse,
    input logic              ser_out,
    input logic              word_start,
    input logic              underrun
);
    logic [CODE_W-1:0] sel_q;
    logic [CNT_W-1:0]  since;
    logic [CNT_W-1:0]  wlen;
    logic              seen;

    always_ff @(posedge clk) begin
        sel_q <= width_sel;
        if (rst) begin
            since <= '0;
            wlen  <= '0;
            seen  <= 1'b0;
        end else if (word_start) begin
            wlen  <= width_of(sel_q);
            since <= CNT_W'(1);
            seen  <= 1'b1;
        end else if (since != '1) begin
            since <= since + CNT_W'(1);
        end
    end

    AST_START_ON_TIME: assert property (@(posedge clk) disable iff (rst)
        (seen && word_start) |-> (since == wlen)); // R1

    AST_START_NOT_LATE: assert property (@(posedge clk) disable iff (rst)
        (seen && since == wlen) |-> word_start); // R6

    AST_LSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        (word_start && !underrun && !$past(invert) && !$past(reverse))
            |-> (ser_out == $past(word_lsb))); // R2

    AST_INVERT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (word_start && !underrun && $past(invert) && !$past(reverse))
            |-> (ser_out != $past(word_lsb))); // R4

    AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (rst)
        word_start |-> (underrun == !$past(word_valid))); // R7

    AST_IDLE_FIRST_ONE: assert property (@(posedge clk) disable iff (rst)
        (word_start && underrun) |-> ser_out); // R7

    AST_IDLE_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (underrun && !word_start) |-> (ser_out != $past(ser_out))); // R7
endmodule

bind ser_tx_core ser_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_lsb   (word_in[0]),
    .word_valid (word_valid),
    .width_sel  (width_sel),
    .invert     (invert),
    .reverse    (reverse),
    .ser_out    (ser_out),
    .word_start (word_start),
    .underrun   (underrun)
);

// File: tb/sim_ser_tx_core.sv
`timescale 1ns/1ps
module sim_ser_tx_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [39:0] word_in = '0;
    logic        word_valid = 1'b0;
    logic [2:0]  width_sel = '0;
    logic        invert = 1'b0;
    logic        reverse = 1'b0;
    logic        ser_out, word_start, underrun;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int words  = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    ser_tx_core u0 (
        .clk(clk), .rst(rst), .word_in(word_in), .word_valid(word_valid),
        .width_sel(width_sel), .invert(invert), .reverse(reverse),
        .ser_out(ser_out), .word_start(word_start), .underrun(underrun)
    );

    // ---------------- reference model ----------------
    bit q_bits[$];
    bit exp_out = 0, exp_start = 0, exp_und = 0, cur_und = 0, started = 0;

    function automatic int width_for(input logic [2:0] c);
        int w;
        case (c)
            3'd0: w = 8;   3'd1: w = 10;  3'd2: w = 16;
            3'd3: w = 20;  3'd4: w = 32;  3'd5: w = 40;
            default: w = 10;
        endcase
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q_bits.delete();
            exp_out = 0; exp_start = 0; exp_und = 0; cur_und = 0;
        end else begin
            exp_start = 0;
            if (q_bits.size() == 0) begin
                int w;
                w = width_for(width_sel);
                for (int i = 0; i < w; i++) begin
                    bit b;
                    if (!word_valid) b = (i % 2 == 0);
                    else begin
                        b = reverse ? word_in[w-1-i] : word_in[i];
                        if (invert) b = ~b;
                    end
                    q_bits.push_back(b);
                end
                cur_und   = !word_valid;
                exp_start = 1;
            end
            exp_out = q_bits.pop_front();
            exp_und = cur_und;
        end
        started = 1;
    end

    // ---------------- comparison ----------------
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (ser_out !== exp_out) begin
                errors++;
                $display("FAIL R2 R3 R4 R5 ser_out t=%0t actual=%b expected=%b", $time, ser_out, exp_out);
            end
            checks++;
            if (word_start !== exp_start) begin
                errors++;
                $display("FAIL R1 R6 word_start t=%0t actual=%b expected=%b", $time, word_start, exp_start);
            end
            checks++;
            if (underrun !== exp_und) begin
                errors++;
                $display("FAIL R7 underrun t=%0t actual=%b expected=%b", $time, underrun, exp_und);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    end

    task automatic load_next(input int k);
        logic [63:0] r;
        r = {$urandom(), $urandom()};
        word_in    = r[39:0];
        word_valid = (k % 5 != 2);
        invert     = k[0];
        reverse    = k[1];
        width_sel  = 3'((k / 4) % 8);
    endtask

    task automatic check_reset_state();
        checks++;
        if (ser_out !== 1'b0 || word_start !== 1'b0 || underrun !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset outputs actual=%b%b%b expected=000", ser_out, word_start, underrun);
        end
    endtask

    task automatic run_words(input int n, input int base);
        int k = base;
        while (words < n) begin
            @(negedge clk);
            if (word_start) begin
                words++;
                k++;
                load_next(k);
            end else begin
                // R5: mid-word changes must not matter
                if ($urandom % 3 == 0) invert  = ~invert;
                if ($urandom % 3 == 0) reverse = ~reverse;
                if ($urandom % 5 == 0) word_valid = ~word_valid;
                if ($urandom % 7 == 0) width_sel = 3'($urandom % 8);
                if ($urandom % 4 == 0) begin
                    logic [63:0] r;
                    r = {$urandom(), $urandom()};
                    word_in = r[39:0];
                end
            end
        end
    endtask

    initial begin
        load_next(0);
        repeat (3) @(negedge clk);
        check_reset_state();                 // R8 during reset
        rst = 1'b0;
        run_words(160, 0);

        // mid-run reset, then recovery
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_reset_state();                 // R8 after reset applied mid-word
        load_next(7);
        rst = 1'b0;
        words = 0;
        run_words(40, 200);
        repeat (45) @(negedge clk);
        finish_run();
    end
endmodule